// File: doc/BRIEF.md
# MMU Translation-Table Configuration Register Bank

This block holds the translation-table setup for an instruction MMU and a data MMU. Each MMU has four table base registers and two context configuration registers. The base registers are selected by context class (context zero or any nonzero context) and by page-size slot (0 or 1). The configuration registers are selected by context class only. Software loads them with alternate-space stores, and each store carries an 8-bit space number (ASI) and 64 bits of data. The block decodes the ASI, loads the chosen register with the full store data, and drives every register out in parallel to the pointer-generation logic.

The twelve ASIs handled here are legal only while the extended (hypervisor-capable) mode input is high. When that mode is off, a store to one of them writes nothing and raises an illegal-instruction trap pulse. Stores to any other ASI are left to other blocks: this bank ignores them and does not trap.

The design has no sequencing. A combinational decoder sorts each ASI into one of three access kinds: none, base or config. It also derives the MMU select and the register index. A per-MMU register file then commits the write on the clock edge where the strobe is high.

Top module: `mmu_tt_cfg_bank`

## Requirements
- R1: After reset every base and configuration register of both MMUs reads zero, and the trap output is low.
- R2: With extended mode on, a strobed store to data-MMU ASI 0x31, 0x32, 0x39 or 0x3A loads data base register {ASI[3], ASI[1]}. Index bit 1 (ASI[3]) set selects the nonzero-context pair, so 0x31 loads 0, 0x32 loads 1, 0x39 loads 2 and 0x3A loads 3.
- R3: With extended mode on, a strobed store to instruction-MMU ASI 0x35, 0x36, 0x3D or 0x3E loads instruction base register {ASI[3], ASI[1]}, which is 0, 1, 2 and 3 respectively.
- R4: With extended mode on, a strobed store to ASI 0x33 loads the data context-zero configuration register (index 0), and a store to 0x3B loads the data nonzero-context configuration register (index 1). The index is ASI[3].
- R5: With extended mode on, a strobed store to ASI 0x37 loads instruction configuration register 0 (context zero), and a store to 0x3F loads register 1 (nonzero contexts).
- R6: A legal store copies all 64 data bits into the selected register on the same clock edge, and every other register keeps its value.
- R7: With extended mode off, a strobed store to any of the twelve ASIs changes no register and drives the trap output high in the same cycle as the strobe, for that cycle only.
- R8: A strobed store to any other ASI changes no register and never raises the trap, whatever the mode.
- R9: With the strobe low, no register changes and the trap stays low, whatever the ASI, data and mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store strobe, one per store |
| wr_asi | input | 8 | Address space number of the store |
| wr_data | input | 64 | Store data |
| ext_mode_en | input | 1 | Extended mode enable; the twelve ASIs are legal only while it is high |
| trap_illegal | output | 1 | Illegal-instruction trap pulse, aligned with the offending strobe |
| dmmu_base | output | 4x64 | Data MMU table base registers, index {context nonzero, page slot} |
| dmmu_cfg | output | 2x64 | Data MMU context configuration, index 0 = context zero |
| immu_base | output | 4x64 | Instruction MMU table base registers |
| immu_cfg | output | 2x64 | Instruction MMU context configuration |

## Verification
The bench uses the default DATA_W of 64. With this width, patterns that set the top bit, the bottom bit and alternating bits can show a dropped or shifted data lane in any register. The bench drives all twelve ASIs in both modes. It also drives the near-miss ASIs whose low two bits are zero, and ASIs outside the 0x3X group. A wrong index bit, a swapped MMU select or a misplaced trap condition therefore shows up in a register it should not touch.

// File: rtl/mmu_tt_pkg.sv
package mmu_tt_pkg;

    localparam int ASI_W      = 8;
    localparam int N_MMU      = 2;
    localparam int N_BASE     = 4;
    localparam int N_CFG      = 2;
    localparam int BASE_IDX_W = $clog2(N_BASE);
    localparam int CFG_IDX_W  = $clog2(N_CFG);
    localparam logic [3:0] ASI_GROUP = 4'h3;

    // MMU select encoding carried by ASI bit 2
    localparam logic MMU_DATA  = 1'b0;
    localparam logic MMU_INSTR = 1'b1;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_BASE = 2'd1,
        ACC_CFG  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e              kind;
        logic                   mmu_sel;
        logic [BASE_IDX_W-1:0]  base_idx;
        logic [CFG_IDX_W-1:0]   cfg_idx;
    } asi_dec_t;

endpackage

// File: rtl/mmu_tt_asi_decode.sv
module mmu_tt_asi_decode
    import mmu_tt_pkg::*;
(
    input  logic [ASI_W-1:0] asi,
    output asi_dec_t         dec
);

    logic in_group;

    always_comb begin
        in_group     = (asi[7:4] == ASI_GROUP);
        dec.mmu_sel  = asi[2];
        dec.base_idx = {asi[3], asi[1]};
        dec.cfg_idx  = asi[3];
        dec.kind     = ACC_NONE;
        if (in_group) begin
            unique case (asi[1:0])
                2'b00:        dec.kind = ACC_NONE;
                2'b01, 2'b10: dec.kind = ACC_BASE;
                2'b11:        dec.kind = ACC_CFG;
                default:      dec.kind = ACC_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mmu_tt_reg_file.sv
module mmu_tt_reg_file #(
    parameter int DATA_W = 64,
    parameter int NB     = 4,
    parameter int NC     = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NB-1:0]            base_we,
    input  logic [NC-1:0]            cfg_we,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NB-1:0][DATA_W-1:0] base_q,
    output logic [NC-1:0][DATA_W-1:0] cfg_q
);

    for (genvar b = 0; b < NB; b++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          base_q[b] <= '0;
            else if (base_we[b]) base_q[b] <= wr_data;
        end
    end

    for (genvar c = 0; c < NC; c++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cfg_q[c] <= '0;
            else if (cfg_we[c]) cfg_q[c] <= wr_data;
        end
    end

endmodule

// File: rtl/mmu_tt_cfg_bank.sv
module mmu_tt_cfg_bank
    import mmu_tt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_asi,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          ext_mode_en,
    output logic                          trap_illegal,
    output logic [3:0][DATA_W-1:0]        dmmu_base,
    output logic [1:0][DATA_W-1:0]        dmmu_cfg,
    output logic [3:0][DATA_W-1:0]        immu_base,
    output logic [1:0][DATA_W-1:0]        immu_cfg
);

    asi_dec_t dec;
    logic     hit;
    logic     commit;

    logic [N_MMU-1:0][N_BASE-1:0]             base_we;
    logic [N_MMU-1:0][N_CFG-1:0]              cfg_we;
    logic [N_MMU-1:0][N_BASE-1:0][DATA_W-1:0] base_q;
    logic [N_MMU-1:0][N_CFG-1:0][DATA_W-1:0]  cfg_q;

    mmu_tt_asi_decode u_dec (
        .asi (wr_asi),
        .dec (dec)
    );

    always_comb begin
        hit          = wr_en && (dec.kind != ACC_NONE);
        commit       = hit && ext_mode_en;
        trap_illegal = hit && !ext_mode_en;
    end

    for (genvar m = 0; m < N_MMU; m++) begin : g_mmu
        always_comb begin
            base_we[m] = '0;
            cfg_we[m]  = '0;
            if (commit && (dec.mmu_sel == m[0])) begin
                unique case (dec.kind)
                    ACC_BASE: base_we[m][dec.base_idx] = 1'b1;
                    ACC_CFG:  cfg_we[m][dec.cfg_idx]   = 1'b1;
                    default:  ;
                endcase
            end
        end

        mmu_tt_reg_file #(
            .DATA_W (DATA_W),
            .NB     (N_BASE),
            .NC     (N_CFG)
        ) u_rf (
            .clk     (clk),
            .rst_n   (rst_n),
            .base_we (base_we[m]),
            .cfg_we  (cfg_we[m]),
            .wr_data (wr_data),
            .base_q  (base_q[m]),
            .cfg_q   (cfg_q[m])
        );
    end

    assign dmmu_base = base_q[MMU_DATA];
    assign dmmu_cfg  = cfg_q[MMU_DATA];
    assign immu_base = base_q[MMU_INSTR];
    assign immu_cfg  = cfg_q[MMU_INSTR];

endmodule

// File: rtl/mmu_tt_cfg_bank_chk.sv
module mmu_tt_cfg_bank_chk #(
    parameter int DATA_W = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [7:0]             wr_asi,
    input logic [DATA_W-1:0]      wr_data,
    input logic                   ext_mode_en,
    input logic                   trap_illegal,
    input logic [3:0][DATA_W-1:0] dmmu_base,
    input logic [1:0][DATA_W-1:0] dmmu_cfg,
    input logic [3:0][DATA_W-1:0] immu_base,
    input logic [1:0][DATA_W-1:0] immu_cfg
);

    logic [12*DATA_W-1:0] all_regs;
    assign all_regs = {dmmu_base, dmmu_cfg, immu_base, immu_cfg};

    // R9: a trap needs a strobe
    assert_trap_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |-> wr_en);

    // R8: no trap from this block while extended mode is on
    assert_no_trap_in_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_en |-> !trap_illegal);

    // R7: a trapping store leaves the bank untouched
    assert_trap_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |=> $stable(all_regs));

    // R9: idle cycles hold all state
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(all_regs));

    // R2: ASI 0x3A lands in data base slot 3
    assert_dbase3_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ext_mode_en && wr_asi == 8'h3A) |=> dmmu_base[3] == $past(wr_data));

    // R5: ASI 0x3F lands in instruction nonzero-context config
    assert_icfg1_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ext_mode_en && wr_asi == 8'h3F) |=> immu_cfg[1] == $past(wr_data));

    // R6: a data config store leaves instruction state alone
    assert_dcfg_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_asi == 8'h33) |=> ($stable(immu_base) && $stable(immu_cfg)));

endmodule

bind mmu_tt_cfg_bank mmu_tt_cfg_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_asi       (wr_asi),
    .wr_data      (wr_data),
    .ext_mode_en  (ext_mode_en),
    .trap_illegal (trap_illegal),
    .dmmu_base    (dmmu_base),
    .dmmu_cfg     (dmmu_cfg),
    .immu_base    (immu_base),
    .immu_cfg     (immu_cfg)
);

// File: tb/sim_mmu_tt_cfg_bank.sv
module sim_mmu_tt_cfg_bank;

    localparam int DW = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_asi = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              ext_mode_en = 1'b0;
    logic              trap_illegal;
    logic [3:0][DW-1:0] dmmu_base;
    logic [1:0][DW-1:0] dmmu_cfg;
    logic [3:0][DW-1:0] immu_base;
    logic [1:0][DW-1:0] immu_cfg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] m_base [2][4];
    logic [DW-1:0] m_cfg  [2][2];

    always #2 clk = ~clk;

    mmu_tt_cfg_bank #(.DATA_W(DW)) u0 (
        .clk, .rst_n, .wr_en, .wr_asi, .wr_data, .ext_mode_en,
        .trap_illegal, .dmmu_base, .dmmu_cfg, .immu_base, .immu_cfg
    );

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 4; i++) begin
            check(req, $sformatf("dmmu_base[%0d]", i), dmmu_base[i], m_base[0][i]);
            check(req, $sformatf("immu_base[%0d]", i), immu_base[i], m_base[1][i]);
        end
        for (int i = 0; i < 2; i++) begin
            check(req, $sformatf("dmmu_cfg[%0d]", i), dmmu_cfg[i], m_cfg[0][i]);
            check(req, $sformatf("immu_cfg[%0d]", i), immu_cfg[i], m_cfg[1][i]);
        end
    endtask

    // One strobed store; expectations follow the ASI encoding in the requirements
    task automatic store(string req, logic [7:0] asi, logic [DW-1:0] data, logic ext, logic strobe);
        logic hit;
        hit = strobe && (asi[7:4] == 4'h3) && (asi[1:0] != 2'b00);
        @(negedge clk);
        wr_en = strobe; wr_asi = asi; wr_data = data; ext_mode_en = ext;
        #1;
        check(req, $sformatf("trap asi %h", asi), {63'd0, trap_illegal}, {63'd0, hit && !ext});
        if (hit && ext) begin
            if (asi[1:0] == 2'b11) m_cfg[asi[2]][asi[3]] = data;
            else                   m_base[asi[2]][{asi[3], asi[1]}] = data;
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(req, "trap after strobe", {63'd0, trap_illegal}, '0);
        check_all(req);
    endtask

    task automatic t_reset_state();
        check("R1", "trap at reset", {63'd0, trap_illegal}, '0);
        check_all("R1");
    endtask

    task automatic t_data_base();
        store("R2", 8'h31, 64'h0000_0000_1111_0001, 1'b1, 1'b1);
        store("R2", 8'h32, 64'h0000_0000_2222_0002, 1'b1, 1'b1);
        store("R2", 8'h39, 64'h0000_0000_3333_0003, 1'b1, 1'b1);
        store("R2", 8'h3A, 64'h0000_0000_4444_0004, 1'b1, 1'b1);
    endtask

    task automatic t_instr_base();
        store("R3", 8'h35, 64'hA000_0000_0000_0005, 1'b1, 1'b1);
        store("R3", 8'h36, 64'hB000_0000_0000_0006, 1'b1, 1'b1);
        store("R3", 8'h3D, 64'hC000_0000_0000_0007, 1'b1, 1'b1);
        store("R3", 8'h3E, 64'hD000_0000_0000_0008, 1'b1, 1'b1);
    endtask

    task automatic t_data_cfg();
        store("R4", 8'h33, 64'h0000_0000_0000_0305, 1'b1, 1'b1);
        store("R4", 8'h3B, 64'h0000_0000_0000_0701, 1'b1, 1'b1);
    endtask

    task automatic t_instr_cfg();
        store("R5", 8'h37, 64'h0000_0000_0000_0602, 1'b1, 1'b1);
        store("R5", 8'h3F, 64'h0000_0000_0000_0104, 1'b1, 1'b1);
    endtask

    task automatic t_full_width();
        store("R6", 8'h39, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        store("R6", 8'h39, 64'h8000_0000_0000_0001, 1'b1, 1'b1);
        store("R6", 8'h36, 64'h5555_AAAA_5555_AAAA, 1'b1, 1'b1);
        store("R6", 8'h3B, 64'hAAAA_5555_AAAA_5555, 1'b1, 1'b1);
    endtask

    task automatic t_trap_disabled();
        logic [7:0] asis [12] = '{8'h31, 8'h32, 8'h39, 8'h3A, 8'h35, 8'h36,
                                  8'h3D, 8'h3E, 8'h33, 8'h3B, 8'h37, 8'h3F};
        for (int i = 0; i < 12; i++)
            store("R7", asis[i], 64'hDEAD_BEEF_0000_0000 | 64'(i), 1'b0, 1'b1);
    endtask

    task automatic t_foreign_asi();
        logic [7:0] asis [8] = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h21, 8'h43, 8'hB1, 8'h7F};
        for (int i = 0; i < 8; i++) begin
            store("R8", asis[i], 64'hFACE_0000_0000_0000 | 64'(i), 1'b1, 1'b1);
            store("R8", asis[i], 64'hCAFE_0000_0000_0000 | 64'(i), 1'b0, 1'b1);
        end
    endtask

    task automatic t_idle_strobe();
        store("R9", 8'h31, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0);
        store("R9", 8'h3F, 64'h0FED_CBA9_8765_4321, 1'b1, 1'b0);
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 4; i++) m_base[m][i] = '0;
            for (int i = 0; i < 2; i++) m_cfg[m][i]  = '0;
        end
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_data_base();
        t_instr_base();
        t_data_cfg();
        t_instr_cfg();
        t_full_width();
        t_trap_disabled();
        t_foreign_asi();
        t_idle_strobe();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule